// File: doc/BRIEF.md
# Dual-Clock Two-Port Static Memory with Split Byte and Extra-Bit Lanes

This block is a true two-port synchronous memory of 4096 words by 9 bits. Each port runs on its own clock and can read or write in the same cycle as the other. On every port the address, write data, select and lane mode inputs are captured on the rising clock edge. An active-low clock enable can freeze that capture. Each word is split into two lanes: an 8-bit byte lane in bits 7:0 and a 1-bit extra lane in bit 8. Each lane has its own mode input (1 = read, 0 = write) and its own active-low output enable.

Outputs are not tri-state pins. Each port presents its read word on a plain data bus, plus one drive flag per lane that says when that lane would be driving. The ports are plain memory-style pins with no valid/ready flow control: the caller owns the cycle timing. The block accepts a new access at every enabled edge and never applies back-pressure.

A write is registered at one edge and lands in the array at the next edge. A lane that was in read mode at the previous enabled edge needs one dead cycle before its write is trustworthy. Internally each port owns a storage bank. A per-lane tag pair records which bank holds the newest copy of each lane, so each bank has a single writer.

Top module: `dpram_split`

## Requirements
- R1: The array holds 2^12 words of 9 bits. A word written through either port is returned by the other port for any read registered after the write has been stored.
- R2: A read is registered at an enabled edge when select is low and the lane mode is 1. The word at that address appears on the port's read bus after that edge, not before, and stays there until the next enabled edge.
- R3: While the clock enable is high at a rising edge, every input register of that port holds. The read bus and the drive flags keep their values even when address, select or mode inputs change.
- R4: Bits 7:0 form the byte lane and bit 8 the extra lane. A write on one lane leaves the other lane of the same word unchanged, including when the two lanes of one word are written through different ports.
- R5: Each lane's drive flag is high exactly when the port is selected, that lane is registered in read mode, and its output enable is low. The output enable acts combinationally, with no clock edge needed.
- R6: A lane registered in write mode never raises its drive flag, whatever its output enable.
- R7: A write registered at edge k (select low, lane mode 0) is stored at edge k+1. A read of that address on the same port that is registered at edge k+2 or later returns the new data.
- R8: A lane write registered while that lane was in read mode at the previous enabled edge stores an undefined value on that lane only. An immediately following write to the same address stores correctly. If select is high during that dead cycle, nothing is stored.
- R9: Select high at an enabled edge deselects the port. Both drive flags go low after that edge, and no write is stored at the following edge.
- R10: A synchronous active-high reset leaves the port deselected with both lanes in read mode and aborts a pending write. The drive flags are low after reset, and the array keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of port A |
| rst_a | input | 1 | Synchronous reset of port A, active high |
| a_clk_en_n | input | 1 | Port A input register enable, active low (high holds) |
| a_sel_n | input | 1 | Port A select, active low |
| a_addr | input | 12 | Port A word address |
| a_wdata | input | 9 | Port A write word (bit 8 = extra lane) |
| a_byte_rd | input | 1 | Port A byte lane mode, 1 read / 0 write |
| a_extra_rd | input | 1 | Port A extra lane mode, 1 read / 0 write |
| a_byte_oe_n | input | 1 | Port A byte lane output enable, active low |
| a_extra_oe_n | input | 1 | Port A extra lane output enable, active low |
| a_rdata | output | 9 | Port A read word |
| a_byte_drv | output | 1 | Port A byte lane drive flag |
| a_extra_drv | output | 1 | Port A extra lane drive flag |
| clk_b | input | 1 | Clock of port B |
| rst_b | input | 1 | Synchronous reset of port B, active high |
| b_clk_en_n | input | 1 | Port B input register enable, active low (high holds) |
| b_sel_n | input | 1 | Port B select, active low |
| b_addr | input | 12 | Port B word address |
| b_wdata | input | 9 | Port B write word (bit 8 = extra lane) |
| b_byte_rd | input | 1 | Port B byte lane mode, 1 read / 0 write |
| b_extra_rd | input | 1 | Port B extra lane mode, 1 read / 0 write |
| b_byte_oe_n | input | 1 | Port B byte lane output enable, active low |
| b_extra_oe_n | input | 1 | Port B extra lane output enable, active low |
| b_rdata | output | 9 | Port B read word |
| b_byte_drv | output | 1 | Port B byte lane drive flag |
| b_extra_drv | output | 1 | Port B extra lane drive flag |

## Verification
A wrong bank tag shows up as a stale lane value. It appears on the next read of that word on either port, one edge after the read is registered, and the full-array write-then-read sweep across ports exposes it at every address. A wrong mode or lane-history register shows up in two ways. The drive flags are wrong right after the edge that loaded it. Or a rewritten word reads back corrupted two edges after the clean write was registered. A register that fails to hold under a high clock enable changes the read bus at the very next edge.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int PORTS      = 2;
  localparam int LANES      = 2;
  localparam int LANE_BYTE  = 0;
  localparam int LANE_EXTRA = 1;

  typedef enum logic {
    MODE_WRITE = 1'b0,
    MODE_READ  = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/dpram_bank.sv
module dpram_bank
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8,
  parameter int N_DRD  = 2,
  parameter int N_TRD  = 4
) (
  input  logic                clk,
  input  logic [LANES-1:0]    we,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [BYTE_W:0]     wdata,
  input  logic [LANES-1:0]    wtag,
  input  logic [ADDR_W-1:0]   d_raddr [N_DRD],
  output logic [BYTE_W:0]     d_rdata [N_DRD],
  input  logic [ADDR_W-1:0]   t_raddr [N_TRD],
  output logic [LANES-1:0]    t_rdata [N_TRD]
);
  localparam int WORD_W = BYTE_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [WORD_W-1:0] BYTE_BITS = WORD_W'({BYTE_W{1'b1}});

  logic [WORD_W-1:0] store [DEPTH];
  logic [LANES-1:0]  tags  [DEPTH];
  logic [WORD_W-1:0] wmask;

  assign wmask = ({WORD_W{we[LANE_EXTRA]}} & ~BYTE_BITS) |
                 ({WORD_W{we[LANE_BYTE]}}  &  BYTE_BITS);

  // Single writer per bank: only the owning port's clock touches it.
  always_ff @(posedge clk) begin
    if (|we) begin
      store[waddr] <= (store[waddr] & ~wmask) | (wdata & wmask);
      tags[waddr]  <= (tags[waddr] & ~we) | (wtag & we);
    end
  end

  for (genvar r = 0; r < N_DRD; r++) begin : g_drd
    assign d_rdata[r] = store[d_raddr[r]];
  end
  for (genvar r = 0; r < N_TRD; r++) begin : g_trd
    assign t_rdata[r] = tags[t_raddr[r]];
  end
endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W:0]   wdata,
  input  logic [LANES-1:0]  lane_rd,
  input  logic [LANES-1:0]  lane_oe_n,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [BYTE_W:0]   fetch_word,
  output logic [LANES-1:0]  commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [BYTE_W:0]   commit_data,
  output logic [BYTE_W:0]   rdata,
  output logic [LANES-1:0]  lane_drv
);
  localparam int WORD_W = BYTE_W + 1;
  localparam logic [WORD_W-1:0] BYTE_BITS = WORD_W'({BYTE_W{1'b1}});

  logic                load;
  logic                sel_n_q;
  logic [LANES-1:0]    mode_q;
  logic [LANES-1:0]    hist_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [WORD_W-1:0]   din_q;
  logic [WORD_W-1:0]   dout_q;
  logic [WORD_W-1:0]   flip;

  assign load = !clk_en_n;

  // Control registers: reset to deselected, all lanes reading.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_n_q <= 1'b1;
      mode_q  <= {LANES{MODE_READ}};
      hist_q  <= {LANES{MODE_READ}};
    end else if (load) begin
      sel_n_q <= sel_n;
      mode_q  <= lane_rd;
      hist_q  <= mode_q;
    end
  end

  // Datapath registers, not reset.
  always_ff @(posedge clk) begin
    if (load) begin
      addr_q <= addr;
      din_q  <= wdata;
      dout_q <= fetch_word;
    end
  end

  assign fetch_addr = addr;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign commit_en[l] = !rst && !sel_n_q && (mode_q[l] == MODE_WRITE);
    assign lane_drv[l]  = !sel_n_q && (mode_q[l] == MODE_READ) && !lane_oe_n[l];
  end

  // A lane whose previous mode was read is in its turnaround cycle:
  // its stored bits are not trustworthy.
  assign flip = ({WORD_W{hist_q[LANE_EXTRA]}} & ~BYTE_BITS) |
                ({WORD_W{hist_q[LANE_BYTE]}}  &  BYTE_BITS);

  assign commit_addr = addr_q;
  assign commit_data = din_q ^ flip;
  assign rdata       = dout_q;
endmodule

// File: rtl/dpram_split.sv
module dpram_split
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic              a_clk_en_n,
  input  logic              a_sel_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [BYTE_W:0]   a_wdata,
  input  logic              a_byte_rd,
  input  logic              a_extra_rd,
  input  logic              a_byte_oe_n,
  input  logic              a_extra_oe_n,
  output logic [BYTE_W:0]   a_rdata,
  output logic              a_byte_drv,
  output logic              a_extra_drv,
  input  logic              clk_b,
  input  logic              rst_b,
  input  logic              b_clk_en_n,
  input  logic              b_sel_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [BYTE_W:0]   b_wdata,
  input  logic              b_byte_rd,
  input  logic              b_extra_rd,
  input  logic              b_byte_oe_n,
  input  logic              b_extra_oe_n,
  output logic [BYTE_W:0]   b_rdata,
  output logic              b_byte_drv,
  output logic              b_extra_drv
);
  localparam int WORD_W = BYTE_W + 1;
  localparam int N_TRD  = 2 * PORTS;
  localparam logic [WORD_W-1:0] BYTE_BITS = WORD_W'({BYTE_W{1'b1}});

  logic              clk_v   [PORTS];
  logic              rst_v   [PORTS];
  logic              en_n_v  [PORTS];
  logic              sel_n_v [PORTS];
  logic [ADDR_W-1:0] addr_v  [PORTS];
  logic [WORD_W-1:0] wd_v    [PORTS];
  logic [LANES-1:0]  rd_v    [PORTS];
  logic [LANES-1:0]  oe_n_v  [PORTS];
  logic [WORD_W-1:0] q_v     [PORTS];
  logic [LANES-1:0]  drv_v   [PORTS];

  logic [ADDR_W-1:0] fetch_addr [PORTS];
  logic [WORD_W-1:0] fetch_word [PORTS];
  logic [LANES-1:0]  cm_en      [PORTS];
  logic [ADDR_W-1:0] cm_addr    [PORTS];
  logic [WORD_W-1:0] cm_data    [PORTS];
  logic [LANES-1:0]  cm_tag     [PORTS];

  logic [ADDR_W-1:0] t_raddr [N_TRD];
  logic [WORD_W-1:0] bank_d  [PORTS][PORTS];
  logic [LANES-1:0]  bank_t  [PORTS][N_TRD];

  assign clk_v[0]   = clk_a;        assign clk_v[1]   = clk_b;
  assign rst_v[0]   = rst_a;        assign rst_v[1]   = rst_b;
  assign en_n_v[0]  = a_clk_en_n;   assign en_n_v[1]  = b_clk_en_n;
  assign sel_n_v[0] = a_sel_n;      assign sel_n_v[1] = b_sel_n;
  assign addr_v[0]  = a_addr;       assign addr_v[1]  = b_addr;
  assign wd_v[0]    = a_wdata;      assign wd_v[1]    = b_wdata;
  assign rd_v[0]    = {a_extra_rd, a_byte_rd};
  assign rd_v[1]    = {b_extra_rd, b_byte_rd};
  assign oe_n_v[0]  = {a_extra_oe_n, a_byte_oe_n};
  assign oe_n_v[1]  = {b_extra_oe_n, b_byte_oe_n};

  assign a_rdata     = q_v[0];
  assign a_byte_drv  = drv_v[0][LANE_BYTE];
  assign a_extra_drv = drv_v[0][LANE_EXTRA];
  assign b_rdata     = q_v[1];
  assign b_byte_drv  = drv_v[1][LANE_BYTE];
  assign b_extra_drv = drv_v[1][LANE_EXTRA];

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [LANES-1:0]  newer_b1;
    logic [WORD_W-1:0] pick_b1;

    dpram_port #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_port (
      .clk         (clk_v[p]),
      .rst         (rst_v[p]),
      .clk_en_n    (en_n_v[p]),
      .sel_n       (sel_n_v[p]),
      .addr        (addr_v[p]),
      .wdata       (wd_v[p]),
      .lane_rd     (rd_v[p]),
      .lane_oe_n   (oe_n_v[p]),
      .fetch_addr  (fetch_addr[p]),
      .fetch_word  (fetch_word[p]),
      .commit_en   (cm_en[p]),
      .commit_addr (cm_addr[p]),
      .commit_data (cm_data[p]),
      .rdata       (q_v[p]),
      .lane_drv    (drv_v[p])
    );

    assign t_raddr[p]         = fetch_addr[p];
    assign t_raddr[PORTS + p] = cm_addr[p];

    // Tags that differ mean bank 1 holds the newest copy of that lane.
    assign newer_b1 = bank_t[0][p] ^ bank_t[1][p];
    assign pick_b1  = ({WORD_W{newer_b1[LANE_EXTRA]}} & ~BYTE_BITS) |
                      ({WORD_W{newer_b1[LANE_BYTE]}}  &  BYTE_BITS);
    assign fetch_word[p] = (bank_d[0][p] & ~pick_b1) | (bank_d[1][p] & pick_b1);

    // Bank 0 writes make the tags equal, bank 1 writes make them differ.
    if (p == 0) begin : g_tag_eq
      assign cm_tag[p] = bank_t[1][PORTS + p];
    end else begin : g_tag_ne
      assign cm_tag[p] = ~bank_t[0][PORTS + p];
    end

    dpram_bank #(
      .ADDR_W (ADDR_W),
      .BYTE_W (BYTE_W),
      .N_DRD  (PORTS),
      .N_TRD  (N_TRD)
    ) u_bank (
      .clk     (clk_v[p]),
      .we      (cm_en[p]),
      .waddr   (cm_addr[p]),
      .wdata   (cm_data[p]),
      .wtag    (cm_tag[p]),
      .d_raddr (fetch_addr),
      .d_rdata (bank_d[p]),
      .t_raddr (t_raddr),
      .t_rdata (bank_t[p])
    );
  end
endmodule

// File: rtl/dpram_port_chk.sv
module dpram_port_chk #(
  parameter int WORD_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en_n,
  input logic              sel_n,
  input logic [1:0]        lane_rd,
  input logic [1:0]        lane_oe_n,
  input logic [WORD_W-1:0] rdata,
  input logic [1:0]        lane_drv
);
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lane_drv == 2'b00));

  p_deselect_release_r9: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && sel_n) |=> (lane_drv == 2'b00));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> $stable(rdata));

  for (genvar l = 0; l < 2; l++) begin : g_lane
    p_write_no_drive_r6: assert property (@(posedge clk) disable iff (rst)
      (!clk_en_n && !sel_n && !lane_rd[l]) |=> !lane_drv[l]);

    p_oe_blocks_r5: assert property (@(posedge clk) disable iff (rst)
      lane_oe_n[l] |-> !lane_drv[l]);

    p_read_drives_r5: assert property (@(posedge clk) disable iff (rst)
      (!clk_en_n && !sel_n && lane_rd[l]) |=> (lane_oe_n[l] || lane_drv[l]));
  end
endmodule

bind dpram_split dpram_port_chk #(.WORD_W(BYTE_W + 1)) u_chk_a (
  .clk       (clk_a),
  .rst       (rst_a),
  .clk_en_n  (a_clk_en_n),
  .sel_n     (a_sel_n),
  .lane_rd   ({a_extra_rd, a_byte_rd}),
  .lane_oe_n ({a_extra_oe_n, a_byte_oe_n}),
  .rdata     (a_rdata),
  .lane_drv  ({a_extra_drv, a_byte_drv})
);

bind dpram_split dpram_port_chk #(.WORD_W(BYTE_W + 1)) u_chk_b (
  .clk       (clk_b),
  .rst       (rst_b),
  .clk_en_n  (b_clk_en_n),
  .sel_n     (b_sel_n),
  .lane_rd   ({b_extra_rd, b_byte_rd}),
  .lane_oe_n ({b_extra_oe_n, b_byte_oe_n}),
  .rdata     (b_rdata),
  .lane_drv  ({b_extra_drv, b_byte_drv})
);

// File: tb/dpram_split_bench.sv
module dpram_split_bench;
  localparam int AW    = 12;
  localparam int BW    = 8;
  localparam int WW    = BW + 1;
  localparam int DEPTH = 1 << AW;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_a = 1'b1;
  logic rst_b = 1'b1;

  always #10 clk_a = ~clk_a;
  initial begin
    #3;
    forever #10 clk_b = ~clk_b;
  end

  logic          a_en_n = 1'b0, a_sel_n = 1'b1, a_brd = 1'b1, a_xrd = 1'b1;
  logic          a_boe_n = 1'b0, a_xoe_n = 1'b0;
  logic [AW-1:0] a_addr = '0;
  logic [WW-1:0] a_wd = '0;
  logic          b_en_n = 1'b0, b_sel_n = 1'b1, b_brd = 1'b1, b_xrd = 1'b1;
  logic          b_boe_n = 1'b0, b_xoe_n = 1'b0;
  logic [AW-1:0] b_addr = '0;
  logic [WW-1:0] b_wd = '0;
  logic [WW-1:0] a_rdata, b_rdata;
  logic          a_byte_drv, a_extra_drv, b_byte_drv, b_extra_drv;

  dpram_split #(.ADDR_W(AW), .BYTE_W(BW)) u_dpram_split (
    .clk_a(clk_a), .rst_a(rst_a), .a_clk_en_n(a_en_n), .a_sel_n(a_sel_n),
    .a_addr(a_addr), .a_wdata(a_wd), .a_byte_rd(a_brd), .a_extra_rd(a_xrd),
    .a_byte_oe_n(a_boe_n), .a_extra_oe_n(a_xoe_n), .a_rdata(a_rdata),
    .a_byte_drv(a_byte_drv), .a_extra_drv(a_extra_drv),
    .clk_b(clk_b), .rst_b(rst_b), .b_clk_en_n(b_en_n), .b_sel_n(b_sel_n),
    .b_addr(b_addr), .b_wdata(b_wd), .b_byte_rd(b_brd), .b_extra_rd(b_xrd),
    .b_byte_oe_n(b_boe_n), .b_extra_oe_n(b_xoe_n), .b_rdata(b_rdata),
    .b_byte_drv(b_byte_drv), .b_extra_drv(b_extra_drv)
  );

  logic [WW-1:0] ref_mem [DEPTH];
  int n_vec = 0;
  int n_bad = 0;

  function automatic logic [WW-1:0] pat(input int a, input int s);
    return WW'((a * 37 + s * 101 + 5) % 512);
  endfunction

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Both tasks start and end at a falling edge of their own clock.
  task automatic a_step(input logic sel_n, input int ad, input logic [WW-1:0] wd,
                        input logic brd, input logic xrd);
    a_en_n = 1'b0; a_sel_n = sel_n; a_addr = AW'(ad); a_wd = wd; a_brd = brd; a_xrd = xrd;
    @(posedge clk_a); @(negedge clk_a);
  endtask

  task automatic b_step(input logic sel_n, input int ad, input logic [WW-1:0] wd,
                        input logic brd, input logic xrd);
    b_en_n = 1'b0; b_sel_n = sel_n; b_addr = AW'(ad); b_wd = wd; b_brd = brd; b_xrd = xrd;
    @(posedge clk_b); @(negedge clk_b);
  endtask

  initial begin
    repeat (150000) @(posedge clk_a);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [WW-1:0] v;
    repeat (3) @(posedge clk_a);
    @(negedge clk_a);
    rst_a = 1'b0;
    rst_b = 1'b0;
    chk("R10 port A idle after reset", WW'({a_extra_drv, a_byte_drv}), '0);
    @(negedge clk_b);
    chk("R10 port B idle after reset", WW'({b_extra_drv, b_byte_drv}), '0);
    @(negedge clk_a);

    // R1: fill whole array through port A (dead cycle deselected first).
    a_step(1'b1, 0, '0, 1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      ref_mem[i] = pat(i, 0);
      a_step(1'b0, i, ref_mem[i], 1'b0, 1'b0);
    end
    a_step(1'b1, 0, '0, 1'b1, 1'b1);

    // R1: read back all of it through port B.
    @(negedge clk_b);
    for (int i = 0; i < DEPTH; i++) begin
      b_step(1'b0, i, '0, 1'b1, 1'b1);
      chk("R1 cross-port sweep", b_rdata, ref_mem[i]);
    end
    chk("R5 B read drives both lanes", WW'({b_extra_drv, b_byte_drv}), WW'(2'b11));

    // R2: new address not visible before the edge, visible after it.
    b_step(1'b0, 8, '0, 1'b1, 1'b1);
    b_addr = AW'(9);
    #5;
    chk("R2 no early update", b_rdata, ref_mem[8]);
    @(posedge clk_b); @(negedge clk_b);
    chk("R2 one-edge latency", b_rdata, ref_mem[9]);
    b_sel_n = 1'b1;

    // R3: stall holds read data and drive flags.
    @(negedge clk_a);
    a_step(1'b0, 5, '0, 1'b1, 1'b1);
    a_en_n = 1'b1; a_addr = AW'(6); a_sel_n = 1'b1; a_brd = 1'b0;
    repeat (3) begin @(posedge clk_a); end
    @(negedge clk_a);
    chk("R3 stall holds data", a_rdata, ref_mem[5]);
    chk("R3 stall holds drive", WW'({a_extra_drv, a_byte_drv}), WW'(2'b11));
    a_step(1'b0, 6, '0, 1'b1, 1'b1);
    chk("R3 release loads new address", a_rdata, ref_mem[6]);

    // R4: A writes byte lane only, B writes extra lane only, same words.
    a_step(1'b1, 0, '0, 1'b0, 1'b1);
    for (int i = 0; i < 256; i++) begin
      v = pat(i, 1);
      ref_mem[i][BW-1:0] = v[BW-1:0];
      a_step(1'b0, i, {~ref_mem[i][BW], v[BW-1:0]}, 1'b0, 1'b1);
    end
    a_step(1'b1, 0, '0, 1'b1, 1'b1);
    @(negedge clk_b);
    b_step(1'b1, 0, '0, 1'b1, 1'b0);
    for (int i = 0; i < 256; i++) begin
      v = pat(i, 2);
      ref_mem[i][BW] = v[0];
      b_step(1'b0, i, {v[0], ~ref_mem[i][BW-1:0]}, 1'b1, 1'b0);
    end
    b_step(1'b1, 0, '0, 1'b1, 1'b1);
    @(negedge clk_a);
    for (int i = 0; i < 256; i++) begin
      a_step(1'b0, i, '0, 1'b1, 1'b1);
      chk("R4 lane independence", a_rdata, ref_mem[i]);
    end

    // R5: output enables act without a clock edge.
    a_step(1'b0, 3, '0, 1'b1, 1'b1);
    a_boe_n = 1'b1;
    #2 chk("R5 byte oe off", WW'({a_extra_drv, a_byte_drv}), WW'(2'b10));
    a_xoe_n = 1'b1;
    #2 chk("R5 both oe off", WW'({a_extra_drv, a_byte_drv}), WW'(2'b00));
    a_boe_n = 1'b0; a_xoe_n = 1'b0;
    #2 chk("R5 both oe on", WW'({a_extra_drv, a_byte_drv}), WW'(2'b11));
    @(negedge clk_a);

    // R6 and R8: byte write straight from read mode (dead cycle, selected).
    a_step(1'b0, 600, 9'h0F0, 1'b0, 1'b1);
    chk("R6 writing lane not driven", WW'({a_extra_drv, a_byte_drv}), WW'(2'b10));
    a_step(1'b0, 600, 9'h03C, 1'b0, 1'b1);
    ref_mem[600][BW-1:0] = 8'h3C;
    a_step(1'b1, 0, '0, 1'b1, 1'b1);
    a_step(1'b0, 600, '0, 1'b1, 1'b1);
    chk("R8 rewrite after dead cycle", a_rdata, ref_mem[600]);

    // R8: dead cycle with select high stores nothing.
    a_step(1'b0, 700, '0, 1'b1, 1'b1);
    a_step(1'b1, 701, 9'h1AA, 1'b0, 1'b0);
    a_step(1'b0, 702, 9'h155, 1'b0, 1'b0);
    ref_mem[702] = 9'h155;
    a_step(1'b1, 0, '0, 1'b1, 1'b1);
    a_step(1'b0, 701, '0, 1'b1, 1'b1);
    chk("R8 deselected dead cycle", a_rdata, ref_mem[701]);
    a_step(1'b0, 702, '0, 1'b1, 1'b1);
    chk("R8 write after deselected dead cycle", a_rdata, ref_mem[702]);

    // R9: deselect while in write mode.
    a_step(1'b1, 800, '0, 1'b0, 1'b0);
    a_step(1'b0, 800, 9'h0A5, 1'b0, 1'b0);
    ref_mem[800] = 9'h0A5;
    a_step(1'b1, 801, 9'h15A, 1'b0, 1'b0);
    chk("R9 deselect releases lanes", WW'({a_extra_drv, a_byte_drv}), '0);
    a_step(1'b1, 0, '0, 1'b1, 1'b1);
    a_step(1'b0, 800, '0, 1'b1, 1'b1);
    chk("R9 write before deselect kept", a_rdata, ref_mem[800]);
    a_step(1'b0, 801, '0, 1'b1, 1'b1);
    chk("R9 no write while deselected", a_rdata, ref_mem[801]);

    // R7: same-port read two edges after write, then other port.
    a_step(1'b1, 900, '0, 1'b0, 1'b0);
    a_step(1'b0, 900, 9'h1C3, 1'b0, 1'b0);
    ref_mem[900] = 9'h1C3;
    a_step(1'b1, 0, '0, 1'b1, 1'b1);
    a_step(1'b0, 900, '0, 1'b1, 1'b1);
    chk("R7 same-port read at k+2", a_rdata, ref_mem[900]);
    @(negedge clk_b);
    b_step(1'b0, 900, '0, 1'b1, 1'b1);
    chk("R7 other-port read after store", b_rdata, ref_mem[900]);
    b_sel_n = 1'b1;

    // R10: reset mid-run quiets outputs and keeps the array.
    @(negedge clk_a);
    a_step(1'b0, 10, '0, 1'b1, 1'b1);
    rst_a = 1'b1;
    @(posedge clk_a); @(negedge clk_a);
    chk("R10 reset releases lanes", WW'({a_extra_drv, a_byte_drv}), '0);
    rst_a = 1'b0;
    a_step(1'b0, 10, '0, 1'b1, 1'b1);
    chk("R10 array survives reset", a_rdata, ref_mem[10]);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule